// File: doc/BRIEF.md
# Synchronous SAR Conversion Sequencer

This block is the digital controller of a 10-bit differential successive-approximation converter. It runs from one system clock and splits every conversion into a fixed frame of twelve clock cycles. The first cycle of a frame samples the input onto the capacitor array. The next ten cycles each resolve one bit. The last cycle is idle and captures the result. The sample rate is therefore the system clock divided by twelve.

During sampling the DAC control word holds a preset pattern: the top bit is high and every other bit is low. The first comparison can therefore start as soon as the sampling switch opens. Each decision cycle raises a single comparator strobe. The comparator answer is taken at the end of that cycle and written into the bit under trial, and the next lower bit is raised for its own trial. A small cycle counter with a decoder selects which bit register position is written on each step.

The finished word goes into an output register with a one-cycle valid pulse. The capacitor array, the comparator, the level shifters and the switches are outside this block.

Top module: `sar_conv_sequencer`

## Requirements
- R1: The conversion result has 10 bits. Bits are resolved strictly from bit 9 down to bit 0, one bit per strobe cycle, and each result bit equals the comparator answer given for that bit.
- R2: A frame is exactly 12 clock cycles: one sampling cycle, ten decision cycles and one idle cycle. sample_o is high in one cycle of every twelve.
- R3: Whenever sample_o is high, dac_o equals 10'b10_0000_0000.
- R4: The first decision uses dac_o = 10'b10_0000_0000. If cmp_i is 1 at the end of that cycle, bit 9 stays 1. If cmp_i is 0, bit 9 is cleared.
- R5: In decision cycle k (k = 1 to 10, bit b = 10 - k), dac_o holds the already decided bits above b, a trial 1 at bit b, and zeros below b.
- R6: cmp_strobe_o is high for exactly the ten cycles after the sampling cycle and is never high together with sample_o. cmp_i is used only at the end of a strobe cycle and has no effect in the sampling and idle cycles.
- R7: At the end of the idle cycle, code_o takes the final word and code_valid_o is high for one cycle, which coincides with the next sampling cycle. code_o does not change at any other time.
- R8: While rst_n is low at a clock edge (synchronous, active low), the frame restarts in the sampling cycle, dac_o returns to the preset pattern, cmp_strobe_o goes low, code_o clears to 0 and code_valid_o goes low. This also applies in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one frame is twelve periods |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_i | input | 1 | Comparator answer; 1 means the positive DAC node is above the negative node |
| sample_o | output | 1 | Top-plate sampling switch control, high in the sampling cycle |
| cmp_strobe_o | output | 1 | Comparator clock, high in each decision cycle |
| dac_o | output | 10 | Bottom-plate DAC bit controls |
| code_o | output | 10 | Last completed conversion code |
| code_valid_o | output | 1 | One-cycle pulse when code_o is updated |

## Verification
The assertions check the following on every cycle:
- the counter wraps after the idle cycle;
- sampling and strobe never overlap;
- the preset pattern is present whenever sample_o is high;
- each selected bit takes the comparator value, and a trial bit goes high in the cycle after it is selected;
- the valid pulse lasts one cycle and the code holds between captures.

Some behaviour can only be shown by the bench scenarios, which drive a comparator model from a known input code:
- the exact trial word seen on dac_o in each of the ten decision cycles;
- that the captured code equals the modelled input for extreme and alternating patterns;
- that comparator noise in the sampling and idle cycles has no effect;
- that a reset in the middle of a frame restarts cleanly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int unsigned SAR_BITS_DFLT = 10;

    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_DECIDE = 2'd1,
        PH_IDLE   = 2'd2
    } sar_phase_e;

endpackage

// File: rtl/sar_step_counter.sv
module sar_step_counter
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES = SAR_BITS_DFLT
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic           sample_q_o,
    output logic           strobe_q_o,
    output logic [RES-1:0] decide_sel_o,
    output logic [RES-1:0] trial_sel_o,
    output logic           frame_end_o
);
    localparam int unsigned FRAME = RES + 2;
    localparam int unsigned CW    = $clog2(FRAME);
    localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sample;
        logic          strobe;
    } ctr_state_t;

    localparam ctr_state_t CTR_RST = '{cnt: '0, sample: 1'b1, strobe: 1'b0};

    ctr_state_t st_q, st_d;
    sar_phase_e ph_d;

    function automatic sar_phase_e phase_of(input logic [CW-1:0] c);
        if (c == '0)
            return PH_SAMPLE;
        else if (c <= CW'(RES))
            return PH_DECIDE;
        else
            return PH_IDLE;
    endfunction

    always_comb begin
        st_d        = st_q;
        st_d.cnt    = (st_q.cnt == LAST) ? '0 : st_q.cnt + CW'(1);
        ph_d        = phase_of(st_d.cnt);
        st_d.sample = (ph_d == PH_SAMPLE);
        st_d.strobe = (ph_d == PH_DECIDE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= CTR_RST;
        else
            st_q <= st_d;
    end

    // Decoder: count k resolves bit RES-k and raises bit RES-k-1 as the next trial.
    for (genvar i = 0; i < RES; i++) begin : g_dec
        assign decide_sel_o[i] = (st_q.cnt == CW'(RES - i));
        if (i < RES - 1) begin : g_trial
            assign trial_sel_o[i] = (st_q.cnt == CW'(RES - i - 1));
        end else begin : g_top
            assign trial_sel_o[i] = 1'b0;
        end
    end

    assign frame_end_o = (st_q.cnt == LAST);
    assign sample_q_o  = st_q.sample;
    assign strobe_q_o  = st_q.strobe;

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> (st_q.cnt == '0) && sample_q_o);
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_q_o && strobe_q_o));
    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(decide_sel_o) && (strobe_q_o == (|decide_sel_o)));

endmodule

// File: rtl/sar_bit_register.sv
module sar_bit_register
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES = SAR_BITS_DFLT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmp_i,
    input  logic [RES-1:0] decide_sel_i,
    input  logic [RES-1:0] trial_sel_i,
    input  logic           preset_ld_i,
    output logic [RES-1:0] bits_o
);
    localparam logic [RES-1:0] PRESET = {1'b1, {(RES-1){1'b0}}};

    typedef struct packed {
        logic [RES-1:0] bits;
    } breg_state_t;

    breg_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (preset_ld_i) begin
            st_d.bits = PRESET;
        end else begin
            for (int i = 0; i < RES; i++) begin
                if (decide_sel_i[i])
                    st_d.bits[i] = cmp_i;
                else if (trial_sel_i[i])
                    st_d.bits[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.bits <= PRESET;
        else
            st_q <= st_d;
    end

    assign bits_o = st_q.bits;

    for (genvar i = 0; i < RES; i++) begin : g_chk
        assert_decide_R4: assert property (@(posedge clk) disable iff (!rst_n)
            decide_sel_i[i] |=> bits_o[i] == $past(cmp_i));
        assert_trial_R5: assert property (@(posedge clk) disable iff (!rst_n)
            trial_sel_i[i] |=> bits_o[i]);
    end
    assert_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        preset_ld_i |=> bits_o == PRESET);

endmodule

// File: rtl/sar_result_capture.sv
module sar_result_capture
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES = SAR_BITS_DFLT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture_i,
    input  logic [RES-1:0] word_i,
    output logic [RES-1:0] code_o,
    output logic           valid_o
);
    typedef struct packed {
        logic [RES-1:0] code;
        logic           valid;
    } cap_state_t;

    cap_state_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.valid = capture_i;
        if (capture_i)
            st_d.code = word_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign code_o  = st_q.code;
    assign valid_o = st_q.valid;

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(code_o));

endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES = SAR_BITS_DFLT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmp_i,
    output logic           sample_o,
    output logic           cmp_strobe_o,
    output logic [RES-1:0] dac_o,
    output logic [RES-1:0] code_o,
    output logic           code_valid_o
);
    localparam logic [RES-1:0] PRESET = {1'b1, {(RES-1){1'b0}}};

    logic [RES-1:0] decide_sel;
    logic [RES-1:0] trial_sel;
    logic           frame_end;

    sar_step_counter #(.RES(RES)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_q_o   (sample_o),
        .strobe_q_o   (cmp_strobe_o),
        .decide_sel_o (decide_sel),
        .trial_sel_o  (trial_sel),
        .frame_end_o  (frame_end)
    );

    sar_bit_register #(.RES(RES)) u_bits (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_i        (cmp_i),
        .decide_sel_i (decide_sel),
        .trial_sel_i  (trial_sel),
        .preset_ld_i  (frame_end),
        .bits_o       (dac_o)
    );

    sar_result_capture #(.RES(RES)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (frame_end),
        .word_i    (dac_o),
        .code_o    (code_o),
        .valid_o   (code_valid_o)
    );

    assert_sample_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> dac_o == PRESET);
    assert_valid_in_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |-> sample_o);

endmodule

// File: tb/sim_sar_conv_sequencer.sv
`timescale 1ns/1ps
module sim_sar_conv_sequencer;
    localparam int RES = 10;
    localparam logic [RES-1:0] PRESET = 10'b10_0000_0000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmp_i = 1'b0;
    logic           sample_o, cmp_strobe_o, code_valid_o;
    logic [RES-1:0] dac_o, code_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [RES-1:0] prev_code = '0;

    always #2 clk = ~clk;

    sar_conv_sequencer #(.RES(RES)) u0 (
        .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i),
        .sample_o(sample_o), .cmp_strobe_o(cmp_strobe_o), .dac_o(dac_o),
        .code_o(code_o), .code_valid_o(code_valid_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [RES-1:0] trial_word(input logic [RES-1:0] vin, input int b);
        logic [RES-1:0] above;
        above = vin & ~((RES'(1) << (b + 1)) - RES'(1));
        return above | (RES'(1) << b);
    endfunction

    // Starts at a falling edge inside a sampling cycle, ends at the next one.
    task automatic run_frame(input logic [RES-1:0] vin, input logic noise);
        chk("R3 preset in sampling", dac_o, PRESET);
        chk("R2 sample high", sample_o, 1'b1);
        chk("R6 no strobe while sampling", cmp_strobe_o, 1'b0);
        cmp_i = noise;
        for (int k = 1; k <= RES; k++) begin
            @(negedge clk);
            chk("R6 strobe in decision", cmp_strobe_o, 1'b1);
            chk("R2 sample low in decision", sample_o, 1'b0);
            if (k == 1)
                chk("R4 first decision word", dac_o, PRESET);
            chk("R5 trial word", dac_o, trial_word(vin, RES - k));
            cmp_i = (vin >= dac_o);
        end
        @(negedge clk);
        cmp_i = noise;
        chk("R6 no strobe in idle", cmp_strobe_o, 1'b0);
        chk("R1 final word", dac_o, vin);
        chk("R7 no valid in idle", code_valid_o, 1'b0);
        chk("R7 code holds", code_o, prev_code);
        @(negedge clk);
        chk("R7 valid pulse", code_valid_o, 1'b1);
        chk("R1 captured code", code_o, vin);
        chk("R2 next frame sampling", sample_o, 1'b1);
        prev_code = vin;
    endtask

    task automatic check_reset_state();
        chk("R8 sample after reset", sample_o, 1'b1);
        chk("R8 strobe after reset", cmp_strobe_o, 1'b0);
        chk("R8 dac after reset", dac_o, PRESET);
        chk("R8 code after reset", code_o, '0);
        chk("R8 valid after reset", code_valid_o, 1'b0);
    endtask

    task automatic mid_frame_reset();
        for (int k = 0; k < 5; k++) begin
            cmp_i = 1'b1;
            @(negedge clk);
        end
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        prev_code = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        run_frame(10'h000, 1'b0);
        run_frame(10'h3FF, 1'b0);
        run_frame(10'h200, 1'b1);
        run_frame(10'h1FF, 1'b1);
        run_frame(10'h2AA, 1'b0);
        run_frame(10'h155, 1'b1);
        run_frame(10'h001, 1'b1);
        run_frame(10'h3FE, 1'b0);
        mid_frame_reset();
        run_frame(10'h0F3, 1'b1);
        run_frame(10'h30C, 1'b0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule